// File: doc/BRIEF.md
# Manchester Stream Decoder

This block turns a stream of one-bit samples into Manchester-decoded data bits. The sampling rate is unknown to the signal, so the caller programs the bit period in samples. The decoder measures the length of each constant-level run between transitions. It sorts each run into one of three kinds: half a period, a whole period, or unusable. A half-period run yields one half-bit symbol and a whole-period run yields two. Consecutive half-bit symbols are paired into data bits.

A pair that cannot be a Manchester cell means the pairing has lost its phase. The decoder then drops one symbol, so the next pair starts one position later, and raises a resynchronisation pulse. The caller also supplies the trace length in samples. If the symbol count grows beyond what that length allows for the programmed period, the period is taken to be wrong: decoding stops and stays stopped until reset. Runs that fit neither length window are reported on a separate pulse and are otherwise dropped.

Top module: `manchester_decoder`

## Requirements
- R1: Samples with `sample_valid_i` low are ignored. Decoding starts at the first valid low-to-high transition. Runs that end before that transition produce no output of any kind.
- R2: With period P, the tolerance is floor(P/4). A run of L samples is short when |L - floor(P/2)| < floor(P/4). A short run yields one half-bit whose value is the level of the run.
- R3: A run that is not short is long when |L - P| < floor(P/4). A long run yields two half-bits, both equal to the level of the run.
- R4: Half-bits are paired in arrival order. The pair (0,1) gives data bit 1 and the pair (1,0) gives data bit 0. Each decoded bit appears on `bit_o` with a one-cycle pulse on `bit_valid_o`.
- R5: A pair of equal half-bits emits no bit. It pulses `resync_o`, drops the first half-bit of the pair, and keeps the second as the start of the next pair.
- R6: A run that is neither short nor long pulses `run_err_o` and yields no half-bits.
- R7: Let n be the half-bit total that would follow a run, with T = `trace_len_i`. If 2*T < (n - 8)*P, then `wrong_clk_o` goes high and stays high until reset. The half-bits of that run are discarded, and every later input is ignored.
- R8: The run-length counter is one bit wider than the period. It saturates at its maximum instead of wrapping, so a very long run is rejected as in R6 and is never folded back into a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | Sampled line level |
| sample_valid_i | input | 1 | Qualifies `sample_i` |
| period_i | input | PERIOD_W | Bit period in samples |
| trace_len_i | input | TRACE_W | Trace length in samples, used for the wrong-clock limit |
| bit_o | output | 1 | Decoded data bit |
| bit_valid_o | output | 1 | One-cycle strobe for `bit_o` |
| resync_o | output | 1 | Pulse when an invalid pair causes a one-symbol slip |
| run_err_o | output | 1 | Pulse when a run fits neither window |
| wrong_clk_o | output | 1 | Sticky flag: decoding stopped because the symbol count exceeded the limit |

## Verification
The hardest case to reach is the slip triggered by a run arriving while no half-bit is held. In that case the two equal halves of a long run collide within a single event. Clean Manchester input never produces it. The stimulus therefore builds exact run lengths: a run of length floor(P/4)+floor(P/2) sits on both window edges at once and is rejected. It is followed by a long run of zeros, which forces the slip with an empty holding slot. Counter saturation is reached with a run more than one counter span long whose wrapped value would land inside the long window.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  typedef enum logic [1:0] {
    RUN_REJECT = 2'd0,
    RUN_SHORT  = 2'd1,
    RUN_LONG   = 2'd2
  } run_kind_e;

  typedef struct packed {
    logic have;
    logic held;
    logic emit;
    logic slip;
  } pair_step_t;

  // One half-bit into the pairing slot.
  function automatic pair_step_t pair_step(input logic have, input logic held, input logic hb);
    pair_step_t r;
    r = '{have: 1'b1, held: hb, emit: 1'b0, slip: 1'b0};
    if (have) begin
      if (held != hb) begin
        r.have = 1'b0;
        r.emit = 1'b1;
      end else begin
        r.slip = 1'b1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/mdec_run_meter.sv
module mdec_run_meter #(
  parameter int RUN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic             valid_i,
  output logic             evt_o,
  output logic [RUN_W-1:0] len_o,
  output logic             lvl_o,
  output logic             armed_o
);
  localparam logic [RUN_W-1:0] CNT_MAX = {RUN_W{1'b1}};

  logic             have_prev_q, prev_q, armed_q, evt_q, lvl_q;
  logic [RUN_W-1:0] cnt_q, len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev_q <= 1'b0;
      prev_q      <= 1'b0;
      armed_q     <= 1'b0;
      evt_q       <= 1'b0;
      lvl_q       <= 1'b0;
      cnt_q       <= '0;
      len_q       <= '0;
    end else begin
      evt_q <= 1'b0;
      if (valid_i) begin
        have_prev_q <= 1'b1;
        prev_q      <= sample_i;
        if (!armed_q) begin
          if (have_prev_q && !prev_q && sample_i) begin
            armed_q <= 1'b1;
            cnt_q   <= RUN_W'(1);
          end
        end else if (sample_i != prev_q) begin
          evt_q <= 1'b1;
          len_q <= cnt_q;
          lvl_q <= prev_q;
          cnt_q <= RUN_W'(1);
        end else if (cnt_q != CNT_MAX) begin
          cnt_q <= cnt_q + RUN_W'(1);
        end
      end
    end
  end

  assign evt_o   = evt_q;
  assign len_o   = len_q;
  assign lvl_o   = lvl_q;
  assign armed_o = armed_q;

  a_r1_no_run_before_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> !evt_q);

  a_r8_count_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && valid_i && sample_i == prev_q && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

endmodule

// File: rtl/mdec_classifier.sv
module mdec_classifier
  import mdec_pkg::*;
#(
  parameter int PERIOD_W = 10,
  parameter int RUN_W    = PERIOD_W + 1
) (
  input  logic [RUN_W-1:0]    len_i,
  input  logic [PERIOD_W-1:0] period_i,
  output run_kind_e           kind_o
);
  logic [RUN_W-1:0] full, half, tol, d_half, d_full;

  always_comb begin
    full   = RUN_W'(period_i);
    half   = full >> 1;
    tol    = full >> 2;
    d_half = (len_i > half) ? len_i - half : half - len_i;
    d_full = (len_i > full) ? len_i - full : full - len_i;
    if (d_half < tol)      kind_o = RUN_SHORT;
    else if (d_full < tol) kind_o = RUN_LONG;
    else                   kind_o = RUN_REJECT;
  end

endmodule

// File: rtl/mdec_pairer.sv
module mdec_pairer
  import mdec_pkg::*;
#(
  parameter int PERIOD_W = 10,
  parameter int TRACE_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                evt_i,
  input  run_kind_e           kind_i,
  input  logic                lvl_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [TRACE_W-1:0]  trace_len_i,
  output logic                bit_o,
  output logic                bit_valid_o,
  output logic                resync_o,
  output logic                run_err_o,
  output logic                wrong_clk_o
);
  localparam int HCNT_W = TRACE_W + 2;
  localparam int PROD_W = HCNT_W + PERIOD_W;

  logic              have_q, held_q, stop_q;
  logic [HCNT_W-1:0] hcnt_q, hcnt_nx;
  logic              over;
  pair_step_t        s1, s2;
  logic              have_nx, held_nx, emit_nx, slip_nx;
  logic [1:0]        n_half;

  always_comb begin
    n_half  = (kind_i == RUN_LONG) ? 2'd2 : (kind_i == RUN_SHORT) ? 2'd1 : 2'd0;
    hcnt_nx = hcnt_q + HCNT_W'(n_half);
    over    = (hcnt_nx > HCNT_W'(8)) &&
              ((PROD_W'(trace_len_i) << 1) <
               (PROD_W'(hcnt_nx - HCNT_W'(8)) * PROD_W'(period_i)));
    s1      = pair_step(have_q, held_q, lvl_i);
    s2      = pair_step(s1.have, s1.held, lvl_i);
    if (n_half == 2'd2) begin
      have_nx = s2.have;
      held_nx = s2.held;
      emit_nx = s1.emit | s2.emit;
      slip_nx = s1.slip | s2.slip;
    end else begin
      have_nx = s1.have;
      held_nx = s1.held;
      emit_nx = s1.emit;
      slip_nx = s1.slip;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q      <= 1'b0;
      held_q      <= 1'b0;
      stop_q      <= 1'b0;
      hcnt_q      <= '0;
      bit_o       <= 1'b0;
      bit_valid_o <= 1'b0;
      resync_o    <= 1'b0;
      run_err_o   <= 1'b0;
    end else begin
      bit_valid_o <= 1'b0;
      resync_o    <= 1'b0;
      run_err_o   <= 1'b0;
      if (evt_i && !stop_q) begin
        if (kind_i == RUN_REJECT) begin
          run_err_o <= 1'b1;
        end else if (over) begin
          stop_q <= 1'b1;
        end else begin
          hcnt_q      <= hcnt_nx;
          have_q      <= have_nx;
          held_q      <= held_nx;
          bit_valid_o <= emit_nx;
          bit_o       <= lvl_i;
          resync_o    <= slip_nx;
        end
      end
    end
  end

  assign wrong_clk_o = stop_q;

  a_r5_slip_emits_nothing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_o |-> !bit_valid_o);

  a_r6_reject_is_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_err_o |-> (!bit_valid_o && !resync_o));

  a_r7_stop_is_final: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrong_clk_o |=> (wrong_clk_o && !bit_valid_o && !resync_o && !run_err_o));

endmodule

// File: rtl/manchester_decoder.sv
module manchester_decoder
  import mdec_pkg::*;
#(
  parameter int PERIOD_W = 10,
  parameter int TRACE_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_i,
  input  logic                sample_valid_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [TRACE_W-1:0]  trace_len_i,
  output logic                bit_o,
  output logic                bit_valid_o,
  output logic                resync_o,
  output logic                run_err_o,
  output logic                wrong_clk_o
);
  localparam int RUN_W = PERIOD_W + 1;

  logic             evt, lvl, armed;
  logic [RUN_W-1:0] len;
  run_kind_e        kind;

  mdec_run_meter #(.RUN_W(RUN_W)) u_meter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sample_i),
    .valid_i (sample_valid_i),
    .evt_o   (evt),
    .len_o   (len),
    .lvl_o   (lvl),
    .armed_o (armed)
  );

  mdec_classifier #(.PERIOD_W(PERIOD_W), .RUN_W(RUN_W)) u_class (
    .len_i   (len),
    .period_i(period_i),
    .kind_o  (kind)
  );

  mdec_pairer #(.PERIOD_W(PERIOD_W), .TRACE_W(TRACE_W)) u_pair (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .kind_i     (kind),
    .lvl_i      (lvl),
    .period_i   (period_i),
    .trace_len_i(trace_len_i),
    .bit_o      (bit_o),
    .bit_valid_o(bit_valid_o),
    .resync_o   (resync_o),
    .run_err_o  (run_err_o),
    .wrong_clk_o(wrong_clk_o)
  );

  a_r1_silent_until_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> (!bit_valid_o && !resync_o && !run_err_o));

endmodule

// File: tb/manchester_decoder_test.sv
module manchester_decoder_test;

  typedef struct packed {
    logic [9:0]  per;
    logic [15:0] pat;
    logic [4:0]  nb;
    logic        gap;
    logic        jit;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{per: 10'd16,  pat: 16'h5A3C, nb: 5'd16, gap: 1'b0, jit: 1'b0},
    '{per: 10'd24,  pat: 16'h3F01, nb: 5'd12, gap: 1'b0, jit: 1'b1},
    '{per: 10'd32,  pat: 16'h0FF0, nb: 5'd16, gap: 1'b1, jit: 1'b1},
    '{per: 10'd64,  pat: 16'h6D92, nb: 5'd10, gap: 1'b0, jit: 1'b1},
    '{per: 10'd255, pat: 16'h4E71, nb: 5'd16, gap: 1'b0, jit: 1'b1},
    '{per: 10'd40,  pat: 16'h1234, nb: 5'd8,  gap: 1'b1, jit: 1'b0}
  };

  logic       clk = 1'b0, rst_n = 1'b0, sample = 1'b0, valid = 1'b0;
  logic [9:0] period = 10'd32;
  logic [15:0] tlen = 16'hFFFF;
  logic bit_o, bit_valid, resync, run_err, wrong_clk;

  int total = 0, bad = 0;
  int ngot = 0, nrs = 0, nerr = 0;
  logic got [256];
  logic hb  [64];
  int   nh;
  logic expb [64];
  int   nexp;

  always #2 clk = ~clk;

  manchester_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sample_valid_i(valid),
    .period_i(period), .trace_len_i(tlen), .bit_o(bit_o), .bit_valid_o(bit_valid),
    .resync_o(resync), .run_err_o(run_err), .wrong_clk_o(wrong_clk)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_valid) begin
        if (ngot < 256) got[ngot] = bit_o;
        ngot++;
      end
      if (resync) nrs++;
      if (run_err) nerr++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    valid = 1'b0;
    sample = 1'b0;
    repeat (3) @(negedge clk);
    ngot = 0; nrs = 0; nerr = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic drive_level(input logic lvl, input int len, input logic gap);
    for (int k = 0; k < len; k++) begin
      sample = lvl;
      valid  = 1'b1;
      @(negedge clk);
      if (gap) begin
        valid  = 1'b0;
        sample = ~lvl;
        @(negedge clk);
      end
    end
  endtask

  task automatic flush();
    valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_halves(input int per, input logic jit, input logic gap);
    int d;
    drive_level(1'b0, 4, gap);
    for (int k = 0; k < nh; k++) begin
      d = (k % 2 == 0) ? per / 2 : per - per / 2;
      if (jit) d = d + ((k % 3 == 0) ? 1 : (k % 3 == 1) ? -1 : 0);
      drive_level(hb[k], d, gap);
    end
    drive_level(~hb[nh-1], per, gap);
    flush();
  endtask

  task automatic compare_bits(input string req);
    check(req, ngot, nexp);
    for (int k = 0; k < nexp && k < ngot; k++) check(req, int'(got[k]), int'(expb[k]));
  endtask

  initial begin
    #(4 * 190000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // reset state
    check("R4 reset bit_valid", int'(bit_valid), 0);
    check("R7 reset wrong_clk", int'(wrong_clk), 0);
    check("R5 reset resync", int'(resync), 0);
    check("R6 reset run_err", int'(run_err), 0);

    // table walk: R2 R3 R4 at several periods, with jitter and invalid gaps (R1)
    for (int v = 0; v < NV; v++) begin
      do_reset();
      period = VECS[v].per;
      tlen   = 16'hFFFF;
      nh = 0; nexp = 0;
      for (int i = 0; i < int'(VECS[v].nb); i++) begin
        logic b;
        b = VECS[v].pat[15-i];
        expb[nexp++] = b;
        hb[nh++] = ~b;
        hb[nh++] = b;
      end
      send_halves(int'(VECS[v].per), VECS[v].jit, VECS[v].gap);
      compare_bits("R4 table decode");
      check("R5 table no resync", nrs, 0);
      check("R6 table no run_err", nerr, 0);
    end

    // R1: leading high run and falling edge before arming give nothing
    do_reset();
    period = 10'd32;
    drive_level(1'b1, 20, 1'b0);
    drive_level(1'b0, 30, 1'b1);
    flush();
    check("R1 pre-arm bits", ngot, 0);
    check("R1 pre-arm run_err", nerr, 0);
    check("R1 pre-arm resync", nrs, 0);
    nh = 0; nexp = 0;
    for (int i = 0; i < 8; i++) begin
      logic b;
      b = (i % 3 == 1);
      expb[nexp++] = b;
      hb[nh++] = ~b;
      hb[nh++] = b;
    end
    send_halves(32, 1'b1, 1'b0);
    compare_bits("R1 decode after arm");

    // R5: injected extra half-bit -> one slip, then realigned pairs
    do_reset();
    period = 10'd32;
    hb[0] = 1; hb[1] = 0; hb[2] = 1; hb[3] = 1; hb[4] = 0; hb[5] = 0; hb[6] = 1;
    nh = 7;
    expb[0] = 0; expb[1] = 0; expb[2] = 1; nexp = 3;
    send_halves(32, 1'b0, 1'b0);
    compare_bits("R5 realign");
    check("R5 one resync pulse", nrs, 1);

    // R6: overlong run rejected, pairing continues around it
    do_reset();
    period = 10'd32;
    drive_level(1'b0, 4, 1'b0);
    drive_level(1'b1, 16, 1'b0);
    drive_level(1'b0, 16, 1'b0);
    drive_level(1'b1, 50, 1'b0);
    drive_level(1'b0, 16, 1'b0);
    drive_level(1'b1, 16, 1'b0);
    drive_level(1'b0, 32, 1'b0);
    flush();
    check("R6 run_err count", nerr, 1);
    check("R6 bits after reject", ngot, 2);
    check("R6 bit0", int'(got[0]), 0);
    check("R6 bit1", int'(got[1]), 1);

    // R2/R3 window edges at P=32: 23 and 9 short, 24 rejected, 25 long; slip from empty slot
    do_reset();
    period = 10'd32;
    drive_level(1'b0, 4, 1'b0);
    drive_level(1'b1, 23, 1'b0);
    drive_level(1'b0, 9, 1'b0);
    drive_level(1'b1, 24, 1'b0);
    drive_level(1'b0, 25, 1'b0);
    drive_level(1'b1, 10, 1'b0);
    flush();
    check("R2 edge short runs bits", ngot, 1);
    check("R2 edge bit value", int'(got[0]), 0);
    check("R6 edge 24 rejected", nerr, 1);
    check("R3 edge long run slips", nrs, 1);

    // R7: T=16,P=32 -> run taking total to 10 halves aborts; 4 bits out
    do_reset();
    period = 10'd32;
    tlen = 16'd16;
    nh = 0;
    for (int i = 0; i < 8; i++) begin hb[nh++] = 1; hb[nh++] = 0; end
    send_halves(32, 1'b0, 1'b0);
    check("R7 bits before abort", ngot, 4);
    check("R7 wrong_clk set", int'(wrong_clk), 1);
    send_halves(32, 1'b0, 1'b0);
    check("R7 ignored after stop", ngot, 4);
    check("R7 wrong_clk sticky", int'(wrong_clk), 1);

    // R7 limit one further: T=32 allows 10 halves -> 5 bits
    do_reset();
    tlen = 16'd32;
    send_halves(32, 1'b0, 1'b0);
    check("R7 limit T=32 bits", ngot, 5);
    check("R7 limit T=32 wrong_clk", int'(wrong_clk), 1);

    // R8: 3068-sample run at P=1020 would wrap into the long window
    do_reset();
    period = 10'd1020;
    tlen = 16'hFFFF;
    drive_level(1'b0, 4, 1'b0);
    drive_level(1'b1, 510, 1'b0);
    drive_level(1'b0, 3068, 1'b0);
    drive_level(1'b1, 100, 1'b0);
    flush();
    check("R8 saturated run rejected", nerr, 1);
    check("R8 no bits", ngot, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule